// File: doc/BRIEF.md
# Delayed Transaction Tracker

This block keeps a small table of delayed read and write requests for a bridge. The initiators of these requests have been told to retry. Each request arriving on the lookup port is compared with every stored entry. A repeat matches only on equal address, bus command and direction, and a write must also carry equal data. A request that matches nothing is stored in a free slot. If no slot is free it is turned away, and the initiator must retry in either case.

When the far side returns data for an entry, the completion port marks that entry done and starts its per-entry countdown from the programmed timeout value. A later repeat of the same request is then reported as ready, and the entry is released once the transfer finishes. If the initiator does not come back before the countdown expires, the entry is dropped on its own. The lookup response is combinational, so it can feed the retry decision in the same cycle.

Top module: `dly_txn_tracker`

## Requirements
- R1: After reset every entry is empty: `vld_vec` is all zero and `q_full` is 0.
- R2: A request hits an entry only when address, command and write flag are all equal. For writes (`req_wr`=1) the data must also be equal. For reads the data input is ignored.
- R3: A request that hits nothing while a slot is free sets `rsp_queued`=1, `rsp_retry`=1 and `rsp_idx` to the lowest empty index. That entry is valid from the next cycle.
- R4: While all entries are valid (`q_full`=1), a request that hits nothing is retried with `rsp_queued`=0 and stores nothing.
- R5: A hit on an entry without completion data gives `rsp_hit`=1, `rsp_ready`=0, `rsp_retry`=1, `rsp_queued`=0, and adds no entry.
- R6: After `cpl_vld` for a valid index, a hit on that entry gives `rsp_ready`=1, `rsp_retry`=0 and `rsp_idx` equal to that index.
- R7: `fin_vld` with `fin_idx` empties that entry on the next clock edge.
- R8: A completed entry that is not finished empties itself exactly `tmo_val`+1 clock edges after the edge that accepted its completion.
- R9: When a timeout release and an insert fall on the same edge, both take effect.
- R10: `cpl_vld` aimed at an empty index changes nothing. A request later stored there is still reported not ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmo_val | input | TW | Countdown loaded on completion |
| req_vld | input | 1 | Lookup/insert request strobe |
| req_addr | input | AW | Request address |
| req_cmd | input | CW | Request bus command |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_data | input | DW | Write data, compared for writes only |
| rsp_hit | output | 1 | Request matches a stored entry |
| rsp_ready | output | 1 | Matching entry has completion data |
| rsp_retry | output | 1 | Initiator must be retried |
| rsp_queued | output | 1 | Request is stored this cycle |
| rsp_idx | output | IW | Hit index, or allocated index |
| cpl_vld | input | 1 | Far-side completion strobe |
| cpl_idx | input | IW | Completed entry index |
| fin_vld | input | 1 | Transfer-finished strobe |
| fin_idx | input | IW | Finished entry index |
| q_full | output | 1 | All entries valid |
| vld_vec | output | DEPTH | Per-entry valid bits |

## Verification
The two functions that can share a cycle are releasing an entry on countdown expiry and inserting a new request. The bench frees one slot, then completes a second entry with a countdown of 1. It presents a new request on exactly the edge where that countdown expires. It then checks that the new request took the pre-existing free slot and that the expired entry is empty as well, reading both from the valid vector on the next falling edge.

// File: rtl/dly_txn_tracker.sv
module dly_txn_tracker #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CW    = 4,
  parameter int TW    = 8,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TW-1:0]    tmo_val,
  input  logic             req_vld,
  input  logic [AW-1:0]    req_addr,
  input  logic [CW-1:0]    req_cmd,
  input  logic             req_wr,
  input  logic [DW-1:0]    req_data,
  output logic             rsp_hit,
  output logic             rsp_ready,
  output logic             rsp_retry,
  output logic             rsp_queued,
  output logic [IW-1:0]    rsp_idx,
  input  logic             cpl_vld,
  input  logic [IW-1:0]    cpl_idx,
  input  logic             fin_vld,
  input  logic [IW-1:0]    fin_idx,
  output logic             q_full,
  output logic [DEPTH-1:0] vld_vec
);

  logic [DEPTH-1:0] vld_q, done_q, wr_q, hit_v;
  logic [AW-1:0]    addr_q [DEPTH];
  logic [CW-1:0]    cmd_q  [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [TW-1:0]    cnt_q  [DEPTH];
  logic [IW-1:0]    hit_idx, free_idx;
  logic             alloc_en;

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      hit_v[i] = vld_q[i] && addr_q[i] == req_addr && cmd_q[i] == req_cmd &&
                 wr_q[i] == req_wr && (!req_wr || data_q[i] == req_data);
    hit_idx  = '0;
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hit_v[i])  hit_idx  = IW'(i);
      if (!vld_q[i]) free_idx = IW'(i);
    end
  end

  assign q_full     = &vld_q;
  assign vld_vec    = vld_q;
  assign rsp_hit    = req_vld && |hit_v;
  assign rsp_ready  = rsp_hit && done_q[hit_idx];
  assign rsp_retry  = req_vld && !rsp_ready;
  assign alloc_en   = req_vld && !(|hit_v) && !q_full;
  assign rsp_queued = alloc_en;
  assign rsp_idx    = rsp_hit ? hit_idx : free_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      done_q <= '0;
      wr_q   <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        addr_q[i] <= '0;
        cmd_q[i]  <= '0;
        data_q[i] <= '0;
        cnt_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (alloc_en && free_idx == IW'(i)) begin
          vld_q[i]  <= 1'b1;
          done_q[i] <= 1'b0;
          wr_q[i]   <= req_wr;
          addr_q[i] <= req_addr;
          cmd_q[i]  <= req_cmd;
          data_q[i] <= req_data;
        end else if ((vld_q[i] && done_q[i] && cnt_q[i] == '0) ||
                     (fin_vld && fin_idx == IW'(i))) begin
          vld_q[i]  <= 1'b0;
          done_q[i] <= 1'b0;
        end else if (cpl_vld && cpl_idx == IW'(i) && vld_q[i]) begin
          done_q[i] <= 1'b1;
          cnt_q[i]  <= tmo_val;
        end else if (done_q[i] && cnt_q[i] != '0) begin
          cnt_q[i]  <= cnt_q[i] - 1'b1;
        end
      end
    end
  end

  // R3
  alloc_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_queued |=> vld_q[$past(rsp_idx)]);

  // R4
  full_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && q_full && !rsp_hit) |-> (rsp_retry && !rsp_queued));

  // R5
  pending_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hit && !rsp_ready) |-> (rsp_retry && !rsp_queued));

  // R6
  cpl_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_vld && vld_q[cpl_idx] && !(fin_vld && fin_idx == cpl_idx)) |=> done_q[$past(cpl_idx)]);

  // R7
  fin_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_vld && vld_q[fin_idx]) |=> !vld_q[$past(fin_idx)]);

endmodule

// File: tb/dly_txn_tracker_tb.sv
module dly_txn_tracker_tb_top;
  localparam int DEPTH = 4, AW = 32, DW = 32, CW = 4, TW = 8, IW = 2;

  logic clk = 0, rst_n = 0;
  logic [TW-1:0] tmo_val = 8'd20;
  logic req_vld = 0, req_wr = 0;
  logic [AW-1:0] req_addr = '0;
  logic [CW-1:0] req_cmd = '0;
  logic [DW-1:0] req_data = '0;
  logic rsp_hit, rsp_ready, rsp_retry, rsp_queued, q_full;
  logic [IW-1:0] rsp_idx;
  logic cpl_vld = 0, fin_vld = 0;
  logic [IW-1:0] cpl_idx = '0, fin_idx = '0;
  logic [DEPTH-1:0] vld_vec;

  typedef struct {
    logic hit, rdy, retry, q;
    logic [IW-1:0] idx;
    string tag;
  } exp_t;
  exp_t exp_q[$];
  int nchk = 0, nfail = 0;

  always #5 clk = ~clk;

  dly_txn_tracker #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .CW(CW), .TW(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tmo_val(tmo_val),
    .req_vld(req_vld), .req_addr(req_addr), .req_cmd(req_cmd), .req_wr(req_wr), .req_data(req_data),
    .rsp_hit(rsp_hit), .rsp_ready(rsp_ready), .rsp_retry(rsp_retry), .rsp_queued(rsp_queued), .rsp_idx(rsp_idx),
    .cpl_vld(cpl_vld), .cpl_idx(cpl_idx), .fin_vld(fin_vld), .fin_idx(fin_idx),
    .q_full(q_full), .vld_vec(vld_vec));

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  always @(negedge clk) begin
    #3;
    if (req_vld) begin
      exp_t e;
      nchk++;
      if (exp_q.size() == 0) begin
        nfail++;
        $display("FAIL monitor: unexpected response, act hit=%0b exp none", rsp_hit);
      end else begin
        e = exp_q.pop_front();
        if ({rsp_hit, rsp_ready, rsp_retry, rsp_queued, rsp_idx} !== {e.hit, e.rdy, e.retry, e.q, e.idx}) begin
          nfail++;
          $display("FAIL %s: act hit=%0b rdy=%0b retry=%0b q=%0b idx=%0d exp hit=%0b rdy=%0b retry=%0b q=%0b idx=%0d",
                   e.tag, rsp_hit, rsp_ready, rsp_retry, rsp_queued, rsp_idx,
                   e.hit, e.rdy, e.retry, e.q, e.idx);
        end
      end
    end
  end

  task automatic send(input logic [AW-1:0] a, input logic [CW-1:0] c, input logic w,
                      input logic [DW-1:0] d, input logic eh, input logic er,
                      input logic eq, input int ei, input string tag);
    exp_t e;
    req_vld = 1; req_addr = a; req_cmd = c; req_wr = w; req_data = d;
    e.hit = eh; e.rdy = er; e.retry = !er; e.q = eq; e.idx = IW'(ei); e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    req_vld = 0;
  endtask

  task automatic cpl(input int i);
    cpl_vld = 1; cpl_idx = IW'(i);
    @(negedge clk);
    cpl_vld = 0;
  endtask

  task automatic fin(input int i);
    fin_vld = 1; fin_idx = IW'(i);
    @(negedge clk);
    fin_vld = 0;
  endtask

  task automatic chk_vec(input logic [DEPTH-1:0] ev, input logic ef, input string tag);
    nchk++;
    if (vld_vec !== ev || q_full !== ef) begin
      nfail++;
      $display("FAIL %s: act vld=%b full=%0b exp vld=%b full=%0b", tag, vld_vec, q_full, ev, ef);
    end
  endtask

  initial begin
    #200000;
    nfail++;
    $display("FAIL watchdog: act running exp finished");
    finish_up();
  end

  initial begin
    repeat (2) @(negedge clk);
    chk_vec(4'b0000, 0, "R1 reset");
    rst_n = 1;
    @(negedge clk);
    chk_vec(4'b0000, 0, "R1 after reset");
    send(32'h100, 4'd6, 0, 0,      0, 0, 1, 0, "R3 first alloc");
    send(32'h200, 4'd7, 1, 32'hAA, 0, 0, 1, 1, "R3 second alloc");
    send(32'h100, 4'd6, 0, 0,      1, 0, 0, 0, "R5 read repeat pending");
    chk_vec(4'b0011, 0, "R5 no new entry");
    send(32'h100, 4'd7, 0, 0,      0, 0, 1, 2, "R2 cmd differs");
    send(32'h200, 4'd7, 1, 32'hAB, 0, 0, 1, 3, "R2 write data differs");
    send(32'h200, 4'd7, 1, 32'hAA, 1, 0, 0, 1, "R5 write repeat pending");
    chk_vec(4'b1111, 1, "R4 full");
    send(32'h300, 4'd6, 0, 0,      0, 0, 0, 0, "R4 full miss");
    chk_vec(4'b1111, 1, "R4 nothing stored");
    cpl(0);
    send(32'h100, 4'd6, 0, 0,      1, 1, 0, 0, "R6 ready hit");
    fin(0);
    chk_vec(4'b1110, 0, "R7 finish frees");
    send(32'h400, 4'd6, 0, 0,      0, 0, 1, 0, "R3 lowest free reused");
    send(32'h400, 4'd6, 0, 32'h55, 1, 0, 0, 0, "R2 read data ignored");
    tmo_val = 8'd3;
    cpl(1);
    repeat (3) @(negedge clk);
    chk_vec(4'b1111, 1, "R8 still held at tmo");
    @(negedge clk);
    chk_vec(4'b1101, 0, "R8 freed at tmo+1");
    send(32'h500, 4'd6, 0, 0,      0, 0, 1, 1, "R3 refill");
    fin(3);
    chk_vec(4'b0111, 0, "R7 finish entry 3");
    tmo_val = 8'd1;
    cpl(2);
    @(negedge clk);
    send(32'h600, 4'd6, 0, 0,      0, 0, 1, 3, "R9 insert with timeout");
    chk_vec(4'b1011, 0, "R9 both took effect");
    tmo_val = 8'd20;
    cpl(2);
    chk_vec(4'b1011, 0, "R10 cpl on empty ignored");
    send(32'h700, 4'd6, 0, 0,      0, 0, 1, 2, "R10 alloc into slot");
    send(32'h700, 4'd6, 0, 0,      1, 0, 0, 2, "R10 not ready");
    nchk++;
    if (exp_q.size() != 0) begin
      nfail++;
      $display("FAIL scoreboard: act %0d left exp 0", exp_q.size());
    end
    finish_up();
  end
endmodule